// File: doc/BRIEF.md
# Instruction Field Decoder and Immediate Generator

This block takes one 16-bit instruction word and, in the same cycle and with no storage, tells the datapath what it is. The top five bits are the opcode. A lookup table set by parameter maps each opcode to one of four layouts: register-register, register-immediate, split-immediate branch, or long jump. Opcodes that the table marks as unused raise a flag.

From the chosen layout the block pulls out the source and destination register numbers (each 0 to 7) and the two-bit function code. It also assembles the layout's immediate and sign-extends it to 16 bits. Any field that the layout does not carry reads as zero, so later stages can use the outputs without qualifying them by format.

The block has no handshake and no clock. The instruction is held by whatever stage feeds it, and every output follows it combinationally. Back-pressure is therefore the job of the surrounding pipeline registers.

Top module: `insdec_top`

## Requirements
- R1: `opcode_o` always equals instruction bits [15:11], for every opcode, legal or not.
- R2: `fmt_o` follows the opcode table, coded 0 = register, 1 = immediate, 2 = branch, 3 = jump. With the default table, opcodes 0–3 are register, 4–15 immediate, 16–23 branch and 24–27 jump.
- R3: An opcode that the table marks unused (28–31 by default) drives `illegal_o` = 1 and `fmt_o` = 0. It also forces `rs1_o`, `rs2_o`, `rd_o`, `func_o` and `imm_o` to zero. Every other opcode drives `illegal_o` = 0.
- R4: Register format: `rs1_o` = bits [10:8], `rs2_o` = bits [7:5], `rd_o` = bits [4:2], `func_o` = bits [1:0], and `imm_o` = 0.
- R5: Immediate format: `rs1_o` = bits [10:8] and `rd_o` = bits [7:5]. `rs2_o` and `func_o` are 0. `imm_o` is bits [4:0] sign-extended to 16 bits.
- R6: Branch format: `rs1_o` = bits [8:6] and `rs2_o` = bits [5:3]. `rd_o` and `func_o` are 0. `imm_o` is the 5-bit value {bits [10:9], bits [2:0]}, sign-extended.
- R7: Jump format: `rs1_o`, `rs2_o`, `rd_o` and `func_o` are 0. `imm_o` is bits [10:0] sign-extended.
- R8: Immediate extremes: the 5-bit forms give 16'hFFF0 for −16 and 16'h000F for +15. The jump form gives 16'hFC00 for −1024 and 16'h03FF for +1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 16 | Instruction word |
| opcode_o | output | 5 | Raw opcode field |
| fmt_o | output | 2 | Layout class: 0 register, 1 immediate, 2 branch, 3 jump |
| illegal_o | output | 1 | Opcode is unused in the table |
| rs1_o | output | 3 | First source register number |
| rs2_o | output | 3 | Second source register number |
| rd_o | output | 3 | Destination register number |
| func_o | output | 2 | Function code for register format |
| imm_o | output | 16 | Sign-extended immediate |

## Verification
The block holds no state, so any fault shows at the ports in the same cycle as the instruction that exposes it. A wrong table entry, a slice taken from the wrong bit position, or a mis-sized sign fill all count as such faults. Each of these flips one specific output for a specific set of instruction words. Sweeping every one of the 65,536 words therefore reaches every such fault, and the failing word pinpoints which field is wrong.

// File: rtl/insdec_pkg.sv
package insdec_pkg;
  localparam int ILEN = 16;
  localparam int OPW  = 5;
  localparam int RSW  = 3;
  localparam int FNW  = 2;
  localparam int SIMM = 5;
  localparam int JIMM = ILEN - OPW;

  typedef enum logic [1:0] {
    FMT_R  = 2'd0,
    FMT_I  = 2'd1,
    FMT_SB = 2'd2,
    FMT_J  = 2'd3
  } fmt_e;
endpackage

// File: rtl/insdec_fmt_lut.sv
module insdec_fmt_lut
  import insdec_pkg::*;
#(
  parameter int OPBITS = 5,
  parameter logic [2*(1<<OPBITS)-1:0] FMT_MAP    = '0,
  parameter logic [(1<<OPBITS)-1:0]   LEGAL_MASK = '1
) (
  input  logic [OPBITS-1:0] op_i,
  output fmt_e              fmt_o,
  output logic              illegal_o
);
  localparam int NOPS = 1 << OPBITS;

  fmt_e tab [NOPS];

  for (genvar g = 0; g < NOPS; g++) begin : g_tab
    assign tab[g] = fmt_e'(FMT_MAP[2*g +: 2]);
  end

  always_comb begin
    illegal_o = !LEGAL_MASK[op_i];
    fmt_o     = illegal_o ? FMT_R : tab[op_i];
  end
endmodule

// File: rtl/insdec_fields.sv
module insdec_fields
  import insdec_pkg::*;
(
  input  logic [ILEN-1:0] instr_i,
  input  fmt_e            fmt_i,
  input  logic            illegal_i,
  output logic [RSW-1:0]  rs1_o,
  output logic [RSW-1:0]  rs2_o,
  output logic [RSW-1:0]  rd_o,
  output logic [FNW-1:0]  func_o
);
  localparam int A_HI = ILEN - OPW - 1;   // first register slot just below opcode
  localparam int B_HI = A_HI - RSW;       // second slot
  localparam int C_HI = B_HI - RSW;       // third slot (register format)
  localparam int S_HI = A_HI - 2;         // branch slots sit after the two high imm bits
  localparam int T_HI = S_HI - RSW;

  always_comb begin
    rs1_o  = '0;
    rs2_o  = '0;
    rd_o   = '0;
    func_o = '0;
    if (!illegal_i) begin
      unique case (fmt_i)
        FMT_R: begin
          rs1_o  = instr_i[A_HI -: RSW];
          rs2_o  = instr_i[B_HI -: RSW];
          rd_o   = instr_i[C_HI -: RSW];
          func_o = instr_i[FNW-1:0];
        end
        FMT_I: begin
          rs1_o = instr_i[A_HI -: RSW];
          rd_o  = instr_i[B_HI -: RSW];
        end
        FMT_SB: begin
          rs1_o = instr_i[S_HI -: RSW];
          rs2_o = instr_i[T_HI -: RSW];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    if (!illegal_i && fmt_i == FMT_J)
      AST_JUMP_NO_REGS: assert ({rs1_o, rs2_o, rd_o, func_o} == '0); // R7
    if (!illegal_i && fmt_i == FMT_SB)
      AST_BRANCH_NO_RD: assert (rd_o == '0 && func_o == '0); // R6
  end
endmodule

// File: rtl/insdec_sext.sv
module insdec_sext #(
  parameter int IN_W  = 5,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] ext_o
);
  localparam int FILL = OUT_W - IN_W;
  assign ext_o = {{FILL{val_i[IN_W-1]}}, val_i};
endmodule

// File: rtl/insdec_immgen.sv
module insdec_immgen
  import insdec_pkg::*;
(
  input  logic [ILEN-1:0] instr_i,
  input  fmt_e            fmt_i,
  input  logic            illegal_i,
  output logic [ILEN-1:0] imm_o
);
  localparam int NSRC = 3;
  localparam int SB_HI_W = 2;
  localparam int SB_LO_W = SIMM - SB_HI_W;
  localparam int HI_TOP  = ILEN - OPW - 1;

  logic [JIMM-1:0] raw [NSRC];
  logic [ILEN-1:0] ext [NSRC];

  // source 0: immediate form, 1: branch form, 2: jump form
  assign raw[0] = JIMM'(instr_i[SIMM-1:0]);
  assign raw[1] = JIMM'({instr_i[HI_TOP -: SB_HI_W], instr_i[SB_LO_W-1:0]});
  assign raw[2] = instr_i[JIMM-1:0];

  for (genvar s = 0; s < NSRC; s++) begin : g_ext
    localparam int W = (s == NSRC - 1) ? JIMM : SIMM;
    insdec_sext #(.IN_W(W), .OUT_W(ILEN)) u_sx (
      .val_i (raw[s][W-1:0]),
      .ext_o (ext[s])
    );
  end

  always_comb begin
    imm_o = '0;
    if (!illegal_i) begin
      unique case (fmt_i)
        FMT_I:   imm_o = ext[0];
        FMT_SB:  imm_o = ext[1];
        FMT_J:   imm_o = ext[2];
        default: imm_o = '0;
      endcase
    end
  end

  always_comb begin
    if (!illegal_i && fmt_i == FMT_R)
      AST_REG_NO_IMM: assert (imm_o == '0); // R4
    if (!illegal_i && fmt_i == FMT_I)
      AST_IMM_FILL_I: assert (imm_o[ILEN-1:SIMM-1] == '0 || imm_o[ILEN-1:SIMM-1] == '1); // R5
    if (!illegal_i && fmt_i == FMT_SB)
      AST_IMM_FILL_SB: assert (imm_o[ILEN-1:SIMM-1] == '0 || imm_o[ILEN-1:SIMM-1] == '1); // R6
    if (!illegal_i && fmt_i == FMT_J)
      AST_IMM_FILL_J: assert (imm_o[ILEN-1:JIMM-1] == '0 || imm_o[ILEN-1:JIMM-1] == '1); // R7
  end
endmodule

// File: rtl/insdec_top.sv
module insdec_top
  import insdec_pkg::*;
#(
  parameter logic [63:0] FMT_MAP    = 64'h00FF_AAAA_5555_5500,
  parameter logic [31:0] LEGAL_MASK = 32'h0FFF_FFFF
) (
  input  logic [15:0] instr_i,
  output logic [4:0]  opcode_o,
  output logic [1:0]  fmt_o,
  output logic        illegal_o,
  output logic [2:0]  rs1_o,
  output logic [2:0]  rs2_o,
  output logic [2:0]  rd_o,
  output logic [1:0]  func_o,
  output logic [15:0] imm_o
);
  fmt_e fmt;
  logic illegal;

  assign opcode_o = instr_i[ILEN-1 -: OPW];

  insdec_fmt_lut #(
    .OPBITS     (OPW),
    .FMT_MAP    (FMT_MAP),
    .LEGAL_MASK (LEGAL_MASK)
  ) u_lut (
    .op_i      (opcode_o),
    .fmt_o     (fmt),
    .illegal_o (illegal)
  );

  insdec_fields u_fields (
    .instr_i   (instr_i),
    .fmt_i     (fmt),
    .illegal_i (illegal),
    .rs1_o     (rs1_o),
    .rs2_o     (rs2_o),
    .rd_o      (rd_o),
    .func_o    (func_o)
  );

  insdec_immgen u_imm (
    .instr_i   (instr_i),
    .fmt_i     (fmt),
    .illegal_i (illegal),
    .imm_o     (imm_o)
  );

  assign fmt_o     = fmt;
  assign illegal_o = illegal;

  always_comb begin
    if (illegal)
      AST_ILLEGAL_QUIET: assert (imm_o == '0 && {rs1_o, rs2_o, rd_o, func_o} == '0); // R3
  end
endmodule

// File: tb/insdec_top_test.sv
module insdec_top_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic [15:0] instr;
  logic [4:0]  opcode;
  logic [1:0]  fmt;
  logic        illegal;
  logic [2:0]  rs1, rs2, rd;
  logic [1:0]  func;
  logic [15:0] imm;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  insdec_top uut (
    .instr_i   (instr),
    .opcode_o  (opcode),
    .fmt_o     (fmt),
    .illegal_o (illegal),
    .rs1_o     (rs1),
    .rs2_o     (rs2),
    .rd_o      (rd),
    .func_o    (func),
    .imm_o     (imm)
  );

  task automatic chk(string req, string what, int act, int exp, int w);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s instr=%04h actual=%0h expected=%0h", req, what, w, act, exp);
    end
  endtask

  function automatic int sx(int v, int bits);
    return ((v >= (1 << (bits - 1))) ? v - (1 << bits) : v) & 16'hFFFF;
  endfunction

  // Expected outputs derived from the requirements; tag overrides the req name.
  task automatic apply_and_check(int w, string tag);
    int op, ef, ill, e1, e2, ed, efn, ei;
    string rf, ri;
    @(posedge clk);
    instr = w[15:0];
    @(negedge clk);
    op = (w >> 11) & 31;
    ill = (op >= 28) ? 1 : 0;
    ef  = (op < 4) ? 0 : (op < 16) ? 1 : (op < 24) ? 2 : (op < 28) ? 3 : 0;
    e1 = 0; e2 = 0; ed = 0; efn = 0; ei = 0;
    rf = "R3";
    if (!ill) begin
      case (ef)
        0: begin rf = "R4"; e1 = (w >> 8) & 7; e2 = (w >> 5) & 7; ed = (w >> 2) & 7; efn = w & 3; end
        1: begin rf = "R5"; e1 = (w >> 8) & 7; ed = (w >> 5) & 7; ei = sx(w & 31, 5); end
        2: begin rf = "R6"; e1 = (w >> 6) & 7; e2 = (w >> 3) & 7;
                 ei = sx((((w >> 9) & 3) << 3) | (w & 7), 5); end
        default: begin rf = "R7"; ei = sx(w & 2047, 11); end
      endcase
    end
    ri = (tag != "") ? tag : rf;
    chk("R1", "opcode", int'(opcode), op, w);
    chk("R2", "fmt", int'(fmt), ef, w);
    chk("R3", "illegal", int'(illegal), ill, w);
    chk(rf, "rs1", int'(rs1), e1, w);
    chk(rf, "rs2", int'(rs2), e2, w);
    chk(rf, "rd", int'(rd), ed, w);
    chk(rf, "func", int'(func), efn, w);
    chk(ri, "imm", int'(imm), ei, w);
  endtask

  initial begin
    instr = '0;
    // all-zero word: register format, every field zero (R4)
    apply_and_check(16'h0000, "");
    // R8 extremes: I (op 4), SB (op 16), J (op 24)
    apply_and_check((4 << 11) | 16, "R8");     // I  -16 -> FFF0
    apply_and_check((4 << 11) | 15, "R8");     // I  +15 -> 000F
    apply_and_check((16 << 11) | (2 << 9), "R8");        // SB -16
    apply_and_check((16 << 11) | (1 << 9) | 7, "R8");    // SB +15
    apply_and_check((24 << 11) | 1024, "R8");  // J -1024 -> FC00
    apply_and_check((24 << 11) | 1023, "R8");  // J +1023 -> 03FF
    // exhaustive sweep of every instruction word (R1..R7)
    for (int k = 0; k < 65536; k++) apply_and_check(k, "");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule